// File: doc/BRIEF.md
# Hysteretic Threshold Event Monitor

This block watches two digitized comparator pairs and turns them into status bits, sticky event flags and interrupt requests. Channel 0 reports that the supply is low and channel 1 reports that the temperature is high. Each channel has an *assert* input, meaning the measured quantity has crossed its trip level. It also has a separate *deassert* input, meaning the quantity has come back past a release level. The gap between these two levels is the hysteresis band. Inside that band both inputs are quiet, and the status bit keeps its last value.

Both comparator inputs are asynchronous, so each goes through a two-flip-flop synchronizer first. Status bits can only change while the device reports its full-performance mode. In any other mode they are frozen. Every change of a status bit raises that channel's event flag, whether the bit rose or fell. An interrupt line is driven for each channel while its flag and its enable bit are both set. A small register port reads status, flags and enables. It writes the enables and clears flags by writing ones.

Top module: `thr_evt_mon`

## Requirements
- R1: A comparator input that changes just before rising edge E1 affects status only at the third rising edge E3. Status is unchanged after E2, because of the two-stage synchronizer.
- R2: While mode is active, a synchronized assert input sets the channel's status bit to 1. When assert and deassert are both active, assert takes priority.
- R3: While mode is active, a synchronized deassert input with assert inactive clears status to 0. With neither input active, status holds its value.
- R4: A status change in either direction sets the channel's flag at the same edge that updates status.
- R5: `irq_o[i]` is 1 exactly while flag i and enable i are both 1.
- R6: Writing to address 1 clears each flag whose data bit is 1, and leaves flags whose data bit is 0 unchanged. A status change at the same edge as a clear leaves the flag set.
- R7: While `fpm_i` is 0, status bits hold their value and no flag is raised, whatever the comparator inputs do.
- R8: After reset, status, flags and enables are all 0 and `irq_o` is 0.
- R9: In the register map, bit i corresponds to channel i (0 = supply low, 1 = temperature high). Address 0 reads status and ignores writes. Address 1 reads the flags. Address 2 reads and writes the enables. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fpm_i | input | 1 | Full-performance mode; monitoring is active while this is 1 |
| asrt_raw_i | input | NCH | Asynchronous assert-level comparator outputs, one per channel |
| dsrt_raw_i | input | NCH | Asynchronous deassert-level comparator outputs, one per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for the current address (combinational) |
| irq_o | output | NCH | Interrupt request per channel |

## Verification
The assertions check on every cycle that the status bits stay frozen outside full-performance mode. They also check that status rises only on a synchronized assert and falls only on a synchronized deassert. Two further checks cover flags: every status change leaves the flag set, and a flag drops only under a write-one-to-clear of its own bit. Only the bench scenarios can show other behaviour. This covers the exact three-edge latency from the comparator pins, and assert priority when both inputs are active. It also covers a clear colliding with a new change, the register map decoding and enables gating the interrupts. A cycle-by-cycle model compares these against the outputs through long random stretches.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
    localparam logic [1:0] ADR_STATUS = 2'd0;
    localparam logic [1:0] ADR_FLAG   = 2'd1;
    localparam logic [1:0] ADR_ENABLE = 2'd2;

    typedef struct packed {
        logic stat;
        logic flag;
    } chan_state_t;
endpackage

// File: rtl/thr_sync.sv
`timescale 1ns/1ps
module thr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign dout_o = pipe_q[STAGES-1];
endmodule

// File: rtl/thr_chan.sv
`timescale 1ns/1ps
module thr_chan
    import thr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic asrt_i,
    input  logic dsrt_i,
    input  logic clr_i,
    output logic stat_o,
    output logic flag_o
);
    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i) begin
            if (asrt_i)      st_d.stat = 1'b1;
            else if (dsrt_i) st_d.stat = 1'b0;
        end
        // a fresh change outranks a simultaneous clear
        st_d.flag = (st_q.flag & ~clr_i) | (st_d.stat ^ st_q.stat);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/thr_regs.sv
`timescale 1ns/1ps
module thr_regs
    import thr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2,
    parameter int DW  = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [NCH-1:0] stat_i,
    input  logic [NCH-1:0] flag_i,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] clr_o,
    output logic [DW-1:0]  rdata_o
);
    localparam int PAD = DW - NCH;

    typedef struct packed {
        logic [NCH-1:0] en;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  hit_flag, hit_en;
    logic  unused_wdata;

    assign hit_flag     = (addr_i == AW'(ADR_FLAG));
    assign hit_en       = (addr_i == AW'(ADR_ENABLE));
    assign unused_wdata = ^wdata_i[DW-1:NCH];

    always_comb begin
        rg_d = rg_q;
        if (wr_i && hit_en) rg_d.en = wdata_i[NCH-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end

    always_comb begin
        clr_o   = (wr_i && hit_flag) ? wdata_i[NCH-1:0] : '0;
        rdata_o = '0;
        if (addr_i == AW'(ADR_STATUS)) rdata_o = {{PAD{1'b0}}, stat_i};
        else if (hit_flag)             rdata_o = {{PAD{1'b0}}, flag_i};
        else if (hit_en)               rdata_o = {{PAD{1'b0}}, rg_q.en};
    end

    assign en_o = rg_q.en;
endmodule

// File: rtl/thr_evt_mon.sv
`timescale 1ns/1ps
module thr_evt_mon #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 2,
    parameter int DW          = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           fpm_i,
    input  logic [NCH-1:0] asrt_raw_i,
    input  logic [NCH-1:0] dsrt_raw_i,
    input  logic           reg_wr_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic [NCH-1:0] irq_o
);
    localparam int SW = 2 * NCH;

    logic [SW-1:0]  sync_out;
    logic [NCH-1:0] asrt_s, dsrt_s;
    logic [NCH-1:0] chan_stat, chan_flag, chan_clr, en_q;

    thr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({dsrt_raw_i, asrt_raw_i}),
        .dout_o (sync_out)
    );

    assign asrt_s = sync_out[NCH-1:0];
    assign dsrt_s = sync_out[SW-1:NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        thr_chan u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .active_i (fpm_i),
            .asrt_i   (asrt_s[i]),
            .dsrt_i   (dsrt_s[i]),
            .clr_i    (chan_clr[i]),
            .stat_o   (chan_stat[i]),
            .flag_o   (chan_flag[i])
        );
    end

    thr_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (chan_stat),
        .flag_i  (chan_flag),
        .en_o    (en_q),
        .clr_o   (chan_clr),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o = chan_flag & en_q;
endmodule

// File: rtl/thr_evt_mon_chk.sv
`timescale 1ns/1ps
module thr_evt_mon_chk #(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           fpm_i,
    input logic [NCH-1:0] asrt_s,
    input logic [NCH-1:0] dsrt_s,
    input logic [NCH-1:0] stat,
    input logic [NCH-1:0] flag,
    input logic           reg_wr_i,
    input logic [AW-1:0]  reg_addr_i,
    input logic [NCH-1:0] wdata_lo
);
    p_hold_outside_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fpm_i |=> $stable(stat))
        else $error("R7 status moved outside full-performance mode");

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_set_needs_assert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stat[i] && !asrt_s[i]) |=> !stat[i])
            else $error("R2 status rose without synchronized assert");

        p_clear_needs_deassert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat[i] && !dsrt_s[i]) |=> stat[i])
            else $error("R3 status fell without synchronized deassert");

        p_flag_on_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat[i] != $past(stat[i])) |-> flag[i])
            else $error("R4 status change left flag clear");

        p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag[i] && !(reg_wr_i && reg_addr_i == AW'(1) && wdata_lo[i])) |=> flag[i])
            else $error("R6 flag dropped without a clearing write");
    end
endmodule

bind thr_evt_mon thr_evt_mon_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fpm_i      (fpm_i),
    .asrt_s     (asrt_s),
    .dsrt_s     (dsrt_s),
    .stat       (chan_stat),
    .flag       (chan_flag),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_lo   (reg_wdata_i[NCH-1:0])
);

// File: tb/thr_evt_mon_bench.sv
`timescale 1ns/1ps
module thr_evt_mon_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fpm = 1'b1;
    logic [1:0] asrt = '0, dsrt = '0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thr_evt_mon u_thr_evt_mon (
        .clk_i (clk), .rst_ni (rst_n), .fpm_i (fpm),
        .asrt_raw_i (asrt), .dsrt_raw_i (dsrt),
        .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata), .irq_o (irq)
    );

    // behavioural reference model
    logic [3:0] m_pipe[$];
    logic [1:0] m_stat, m_flag, m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pipe = {4'h0, 4'h0};
            m_stat = '0; m_flag = '0; m_en = '0;
        end else begin
            logic [3:0] s;
            logic [1:0] nxt, clr;
            s = m_pipe.pop_front();
            m_pipe.push_back({dsrt, asrt});
            nxt = m_stat;
            for (int c = 0; c < 2; c++) begin
                if (fpm && s[c])          nxt[c] = 1'b1;
                else if (fpm && s[c + 2]) nxt[c] = 1'b0;
            end
            clr = (wr && addr == 2'd1) ? wdata[1:0] : 2'b00;
            m_flag = (m_flag & ~clr) | (nxt ^ m_stat);
            if (wr && addr == 2'd2) m_en = wdata[1:0];
            m_stat = nxt;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        rd(2'd0, v); check({req, " status"}, v, {6'd0, m_stat});
        rd(2'd1, v); check({req, " flag"},   v, {6'd0, m_flag});
        rd(2'd2, v); check({req, " enable"}, v, {6'd0, m_en});
        rd(2'd3, v); check("R9 addr3 zero", v, 8'h00);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // every cycle: interrupt outputs against model
    always @(negedge clk) begin
        if (rst_n && !done) check("R5 irq", {6'd0, irq}, {6'd0, m_flag & m_en});
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R8 reset state
        rd(2'd0, v); check("R8 status after reset", v, 8'h00);
        rd(2'd1, v); check("R8 flag after reset", v, 8'h00);
        rd(2'd2, v); check("R8 enable after reset", v, 8'h00);
        check("R8 irq after reset", {6'd0, irq}, 8'h00);

        // R9 enable write/readback, status write ignored
        wreg(2'd2, 8'hFF);
        rd(2'd2, v); check("R9 enable readback", v, 8'h03);
        wreg(2'd0, 8'hFF);
        rd(2'd0, v); check("R9 status write ignored", v, 8'h00);

        // R1 latency, R2 set, R4 flag, R5 irq on channel 0
        asrt = 2'b01;
        step(2);
        rd(2'd0, v); check("R1 status unchanged after two edges", v, 8'h00);
        step(1);
        rd(2'd0, v); check("R2 status set on third edge", v, 8'h01);
        rd(2'd1, v); check("R4 flag on rising change", v, 8'h01);
        check("R5 irq ch0", {6'd0, irq}, 8'h01);

        // R3 hold in hysteresis band
        asrt = 2'b00;
        step(6);
        rd(2'd0, v); check("R3 status holds with neither input", v, 8'h01);

        // R6 writing zero has no effect, writing one clears
        wreg(2'd1, 8'h00);
        rd(2'd1, v); check("R6 zero write keeps flag", v, 8'h01);
        wreg(2'd1, 8'h01);
        rd(2'd1, v); check("R6 one write clears flag", v, 8'h00);

        // R3 deassert clears, R4 falling change raises flag
        dsrt = 2'b01;
        step(3);
        rd(2'd0, v); check("R3 status cleared", v, 8'h00);
        rd(2'd1, v); check("R4 flag on falling change", v, 8'h01);
        dsrt = 2'b00;
        wreg(2'd1, 8'h03);
        step(3);

        // R7 frozen outside mode
        fpm = 1'b0;
        asrt = 2'b10;
        step(6);
        rd(2'd0, v); check("R7 status frozen outside mode", v, 8'h00);
        rd(2'd1, v); check("R7 no flag outside mode", v, 8'h00);
        fpm = 1'b1;
        step(1);
        rd(2'd0, v); check("R2 temperature channel set", v, 8'h02);
        asrt = 2'b00;
        wreg(2'd1, 8'h02);

        // R2 assert wins over deassert
        asrt = 2'b11; dsrt = 2'b11;
        step(4);
        rd(2'd0, v); check("R2 assert priority", v, 8'h03);
        asrt = 2'b00; dsrt = 2'b00;
        step(3);
        wreg(2'd1, 8'h03);

        // R6 clear collides with a change on channel 0
        dsrt = 2'b01;
        step(2);
        wr = 1'b1; addr = 2'd1; wdata = 8'h01;
        step(1);
        wr = 1'b0;
        rd(2'd1, v); check("R6 change beats simultaneous clear", v, 8'h01);
        rd(2'd0, v); check("R3 status cleared at collision", v, 8'h02);
        dsrt = 2'b00;

        // R5 enable off masks irq while flag remains
        wreg(2'd2, 8'h00);
        check("R5 irq masked by enable", {6'd0, irq}, 8'h00);
        rd(2'd1, v); check("R5 flag kept while masked", v, 8'h01);
        check_regs("R9 directed");

        // random stretch compared to the model each cycle
        for (int k = 0; k < 600; k++) begin
            asrt = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            dsrt = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            fpm  = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 5) == 0) begin
                wr = 1'b1;
                addr = ($urandom_range(0, 1) != 0) ? 2'd1 : 2'd2;
                wdata = 8'($urandom_range(0, 255));
            end else begin
                wr = 1'b0;
            end
            step(1);
            wr = 1'b0;
            if (k % 25 == 0) check_regs("R4 random");
        end
        check_regs("R6 random end");
        done = 1'b1;
        finish_run();
    end
endmodule